// File: doc/BRIEF.md
# Averaged Deadbanded Buffer Length Controller

This block turns a stream of 10-bit readings from a potentiometer converter into a delay-buffer length for an audio effect. Readings arrive with a valid strobe. The block sums them in blocks of 256 and scales each block sum down to a 16-bit candidate length. A candidate below a fixed minimum is raised to that minimum. The candidate replaces the stored target only when it differs from the target by at least a fixed deadband. A new target is always made even. This keeps converter noise and small pot jitter from moving the buffer.

A second register, the active length, follows the target. On each audio sample strobe it moves by two toward the target, and it stays put once it matches. The active length therefore glides to a new setting over many samples and never jumps. Because both lengths are even, the glide lands on the target exactly.

Top module: `buf_len_ctrl`

## Requirements
- R1: After reset, the target length and the active length both read 0x0600, and any partly summed block is discarded.
- R2: Each block sums exactly 256 accepted conversions. The candidate is that sum shifted right by two bits. The sum restarts from zero after every block, so one block has no influence on the next.
- R3: A cycle with adcValid low is not counted and not summed, whatever adcData holds. The target length changes only on the clock edge that accepts the 256th conversion of a block.
- R4: A candidate below 0x0200 is replaced by 0x0200 before any further use, so the target length is never below 0x0200.
- R5: The target length is replaced only when the absolute difference between the clamped candidate and the current target is 0x0040 or more. A difference of 0x003F leaves the target unchanged.
- R6: When the target length is replaced, bit 0 of the stored value is cleared, so the target length is always even.
- R7: On each cycle with sampleStrobe high, the active length rises by 2 if it is below the target, falls by 2 if it is above, and holds if it is equal.
- R8: The active length holds on every cycle with sampleStrobe low, and it never steps past the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adcValid | input | 1 | High for one cycle per converter result |
| adcData | input | 10 | Unsigned converter result |
| sampleStrobe | input | 1 | High for one cycle per audio sample |
| targetLen | output | 16 | Filtered, clamped, even target length |
| activeLen | output | 16 | Length in use, slewing toward targetLen |

## Verification
Some properties are checked on every cycle: both lengths stay even, the target never drops below the minimum, and any target change is at least the deadband. The active length holds without a strobe, steps by exactly two toward the target with one, and the target stays put on cycles with no conversion. Only the bench scenarios can show the arithmetic. These include the block mean and scaling, the clamp, the deadband edge at 0x003F versus 0x0040, and odd candidates being forced even. They also include gaps in the valid strobe being ignored and a reset in mid-block discarding the partial sum.

// File: rtl/buf_len_pkg.sv
package buf_len_pkg;

  parameter int DEF_ADC_W      = 10;
  parameter int DEF_LEN_W      = 16;
  parameter int DEF_ACC_W      = 24;
  parameter int DEF_BLOCK_LOG2 = 8;
  parameter int DEF_AVG_SHIFT  = 2;
  parameter int DEF_MIN_LEN    = 'h0200;
  parameter int DEF_DEADBAND   = 'h0040;
  parameter int DEF_RESET_LEN  = 'h0600;
  parameter int DEF_SLEW_STEP  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic accumulate;
    logic closeBlock;
    logic slewUp;
    logic slewDown;
  } ctrl_t;

  // comparison flags from datapath to control
  typedef struct packed {
    logic activeBelow;
    logic activeAbove;
  } stat_t;

endpackage

// File: rtl/buf_len_seq.sv
module buf_len_seq
  import buf_len_pkg::*;
#(
  parameter int BLOCK_LOG2 = DEF_BLOCK_LOG2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  adcValid,
  input  logic  sampleStrobe,
  input  stat_t stat,
  output ctrl_t ctrl
);

  logic [BLOCK_LOG2-1:0] convCount;
  logic                  lastConv;

  assign lastConv = &convCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convCount <= '0;
    end else if (adcValid) begin
      convCount <= convCount + 1'b1;
    end
  end

  always_comb begin
    ctrl.accumulate = adcValid;
    ctrl.closeBlock = adcValid && lastConv;
    ctrl.slewUp     = sampleStrobe && stat.activeBelow;
    ctrl.slewDown   = sampleStrobe && stat.activeAbove;
  end

endmodule

// File: rtl/buf_len_path.sv
module buf_len_path
  import buf_len_pkg::*;
#(
  parameter int ADC_W     = DEF_ADC_W,
  parameter int LEN_W     = DEF_LEN_W,
  parameter int ACC_W     = DEF_ACC_W,
  parameter int AVG_SHIFT = DEF_AVG_SHIFT,
  parameter int MIN_LEN   = DEF_MIN_LEN,
  parameter int DEADBAND  = DEF_DEADBAND,
  parameter int RESET_LEN = DEF_RESET_LEN,
  parameter int SLEW_STEP = DEF_SLEW_STEP
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [ADC_W-1:0] adcData,
  output stat_t            stat,
  output logic [LEN_W-1:0] targetLen,
  output logic [LEN_W-1:0] activeLen
);

  localparam logic [LEN_W-1:0] MinL   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] DeadL  = LEN_W'(DEADBAND);
  localparam logic [LEN_W-1:0] ResetL = LEN_W'(RESET_LEN);
  localparam logic [LEN_W-1:0] StepL  = LEN_W'(SLEW_STEP);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sumNext;
  logic [ACC_W-1:0] sumScaled;
  logic [LEN_W-1:0] candRaw;
  logic [LEN_W-1:0] candClamped;
  logic [LEN_W-1:0] candDiff;
  logic             bigMove;
  logic [LEN_W-1:0] targetQ;
  logic [LEN_W-1:0] activeQ;

  always_comb begin
    sumNext     = accQ + ACC_W'(adcData);
    sumScaled   = sumNext >> AVG_SHIFT;
    candRaw     = sumScaled[LEN_W-1:0];
    candClamped = (candRaw < MinL) ? MinL : candRaw;
    candDiff    = (candClamped >= targetQ) ? (candClamped - targetQ)
                                           : (targetQ - candClamped);
    bigMove     = candDiff >= DeadL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (ctrl.accumulate) begin
      accQ <= ctrl.closeBlock ? '0 : sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= ResetL;
    end else if (ctrl.closeBlock && bigMove) begin
      targetQ <= {candClamped[LEN_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= ResetL;
    end else if (ctrl.slewUp) begin
      activeQ <= activeQ + StepL;
    end else if (ctrl.slewDown) begin
      activeQ <= activeQ - StepL;
    end
  end

  assign stat.activeBelow = activeQ < targetQ;
  assign stat.activeAbove = activeQ > targetQ;
  assign targetLen = targetQ;
  assign activeLen = activeQ;

endmodule

// File: rtl/buf_len_ctrl.sv
module buf_len_ctrl
  import buf_len_pkg::*;
#(
  parameter int ADC_W      = DEF_ADC_W,
  parameter int LEN_W      = DEF_LEN_W,
  parameter int ACC_W      = DEF_ACC_W,
  parameter int BLOCK_LOG2 = DEF_BLOCK_LOG2,
  parameter int AVG_SHIFT  = DEF_AVG_SHIFT,
  parameter int MIN_LEN    = DEF_MIN_LEN,
  parameter int DEADBAND   = DEF_DEADBAND,
  parameter int RESET_LEN  = DEF_RESET_LEN,
  parameter int SLEW_STEP  = DEF_SLEW_STEP
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adcValid,
  input  logic [ADC_W-1:0] adcData,
  input  logic             sampleStrobe,
  output logic [LEN_W-1:0] targetLen,
  output logic [LEN_W-1:0] activeLen
);

  ctrl_t ctrl;
  stat_t stat;

  buf_len_seq #(
    .BLOCK_LOG2(BLOCK_LOG2)
  ) u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .adcValid    (adcValid),
    .sampleStrobe(sampleStrobe),
    .stat        (stat),
    .ctrl        (ctrl)
  );

  buf_len_path #(
    .ADC_W    (ADC_W),
    .LEN_W    (LEN_W),
    .ACC_W    (ACC_W),
    .AVG_SHIFT(AVG_SHIFT),
    .MIN_LEN  (MIN_LEN),
    .DEADBAND (DEADBAND),
    .RESET_LEN(RESET_LEN),
    .SLEW_STEP(SLEW_STEP)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .adcData  (adcData),
    .stat     (stat),
    .targetLen(targetLen),
    .activeLen(activeLen)
  );

endmodule

// File: rtl/buf_len_ctrl_chk.sv
module buf_len_ctrl_chk #(
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 'h0200,
  parameter int DEADBAND  = 'h0040,
  parameter int RESET_LEN = 'h0600,
  parameter int SLEW_STEP = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             adcValid,
  input logic             sampleStrobe,
  input logic [LEN_W-1:0] targetLen,
  input logic [LEN_W-1:0] activeLen
);

  logic [LEN_W-1:0] prevTarget;
  logic [LEN_W-1:0] jump;

  always_ff @(posedge clk) begin
    if (!rstN) prevTarget <= LEN_W'(RESET_LEN);
    else       prevTarget <= targetLen;
  end

  assign jump = (targetLen >= prevTarget) ? (targetLen - prevTarget)
                                          : (prevTarget - targetLen);

  assert_even_lengths_R6: assert property (@(posedge clk) disable iff (!rstN)
    (targetLen[0] == 1'b0) && (activeLen[0] == 1'b0));

  assert_target_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    targetLen >= LEN_W'(MIN_LEN));

  assert_deadband_jump_R5: assert property (@(posedge clk) disable iff (!rstN)
    (targetLen != prevTarget) |-> (jump >= LEN_W'(DEADBAND)));

  assert_target_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !adcValid |=> $stable(targetLen));

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStrobe || (activeLen == targetLen)) |=> $stable(activeLen));

  assert_slew_up_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && (activeLen < targetLen)) |=>
      (activeLen == $past(activeLen) + LEN_W'(SLEW_STEP)));

  assert_slew_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && (activeLen > targetLen)) |=>
      (activeLen == $past(activeLen) - LEN_W'(SLEW_STEP)));

endmodule

bind buf_len_ctrl buf_len_ctrl_chk #(
  .LEN_W    (LEN_W),
  .MIN_LEN  (MIN_LEN),
  .DEADBAND (DEADBAND),
  .RESET_LEN(RESET_LEN),
  .SLEW_STEP(SLEW_STEP)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .adcValid    (adcValid),
  .sampleStrobe(sampleStrobe),
  .targetLen   (targetLen),
  .activeLen   (activeLen)
);

// File: tb/sim_buf_len_ctrl.sv
module sim_buf_len_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcValid = 1'b0;
  logic [9:0]  adcData = '0;
  logic        sampleStrobe = 1'b0;
  logic [15:0] targetLen;
  logic [15:0] activeLen;

  int checks = 0;
  int fails = 0;
  int expT = 'h600;
  int expA = 'h600;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  buf_len_ctrl u0 (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .adcData(adcData),
    .sampleStrobe(sampleStrobe), .targetLen(targetLen), .activeLen(activeLen)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; adcValid = 1'b0; sampleStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expT = 'h600; expA = 'h600;
  endtask

  // 256 conversions: first k are base+1, the rest base; optional invalid gaps
  task automatic feedBlock(int base, int k, bit gaps, string tag);
    int sum = 0;
    int cand, diff;
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 16 == 3)) begin
        @(negedge clk);
        adcValid = 1'b0; adcData = 10'd1023;
      end
      if (i == 255) begin
        @(negedge clk);
        adcValid = 1'b0; adcData = 10'd1023;
        chk({tag, " R3 target held before last conversion"}, int'(targetLen), expT);
      end
      @(negedge clk);
      adcValid = 1'b1;
      adcData = 10'((i < k) ? base + 1 : base);
      sum += (i < k) ? base + 1 : base;
    end
    @(negedge clk);
    adcValid = 1'b0;
    cand = sum / 4;
    if (cand < 'h200) cand = 'h200;
    diff = (cand > expT) ? cand - expT : expT - cand;
    if (diff >= 'h40) expT = cand & ~1;
    chk({tag, " R2 R4 R5 R6 target after block"}, int'(targetLen), expT);
    chk({tag, " R8 active held without strobe"}, int'(activeLen), expA);
  endtask

  task automatic slew(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleStrobe = 1'b1;
      if (expA < expT) expA += 2;
      else if (expA > expT) expA -= 2;
    end
    @(negedge clk);
    sampleStrobe = 1'b0;
    chk({tag, " R7 active after strobes"}, int'(activeLen), expA);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R1 reset target", int'(targetLen), 'h600);
    chk("R1 reset active", int'(activeLen), 'h600);

    // R5: equal and just-inside-deadband candidates leave target alone
    feedBlock(24, 0, 1'b0, "equal");
    feedBlock(24, 252, 1'b0, "R5 up by 0x3F");
    feedBlock(23, 4, 1'b1, "R5 down by 0x3F");
    feedBlock(23, 0, 1'b0, "R5 down by 0x40");
    chk("R5 boundary update", int'(targetLen), 'h5C0);

    // R6: odd candidate stored even; gaps exercise R3
    feedBlock(30, 4, 1'b1, "R6 odd candidate");
    chk("R6 odd forced even", int'(targetLen), 'h780);

    // R4: clamp
    feedBlock(2, 0, 1'b0, "R4 clamp");
    chk("R4 clamped target", int'(targetLen), 'h200);
    feedBlock(0, 0, 1'b1, "R4 zero input");

    // R7/R8: glide down to target and stop exactly
    slew(511, "R7 glide one short");
    chk("R7 one step left", int'(activeLen), 'h202);
    slew(1, "R8 land on target");
    chk("R8 landed", int'(activeLen), 'h200);
    slew(5, "R7 hold when equal");
    chk("R7 held at target", int'(activeLen), 'h200);

    // R2/R1: reset in mid-block discards partial sum
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      adcValid = 1'b1; adcData = 10'd1023;
    end
    doReset();
    chk("R1 reset target again", int'(targetLen), 'h600);
    chk("R1 reset active again", int'(activeLen), 'h600);
    feedBlock(24, 0, 1'b0, "R2 partial sum discarded");
    chk("R2 no leftover sum", int'(targetLen), 'h600);

    // sweep of input levels with varying fraction and glides both ways
    for (int v = 0; v <= 992; v += 31) begin
      feedBlock(v, (v * 7) % 256, v[0], "sweep");
      slew(300, "sweep glide");
    end
    slew(40000, "final glide");
    chk("R8 final active equals target", int'(activeLen), expT);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule